// File: doc/BRIEF.md
# Indirect-Access Forwarding Table Store

This block holds the entries of a switch's address-lookup table and exposes them to software through a small register window. Each entry is 68 bits wide. Software never addresses an entry directly. It stages the entry in three 32-bit data-word registers and then writes a table-control register. That write carries an entry index and a commit flag. With the flag set, the staged words are stored into the indexed entry. With it clear, the indexed entry is copied into the data words so that later reads return it.

A global control register holds an enable bit, an ageout bit and a clear bit. Writing the clear bit starts a hardware sweep. The sweep visits one entry per clock and sets each entry's two-bit type field to free, leaving the rest of the entry as it was. The sweep is driven by a two-state machine. `ST_IDLE` moves to `ST_SWEEP` when a global-control write has bit 30 set. `ST_SWEEP` returns to `ST_IDLE` in the cycle it frees the last index (DEPTH-1). While the machine is in `ST_SWEEP`, the clear bit and a busy bit read as 1, and table-control writes are refused. The register window also holds an identification register and one control register for each port.

Top module: `fwd_table_regs`

## Requirements
- R1: After reset the global control register, the table-control register and all three data words read 0, and the read-data port is 0.
- R2: Address 0x00 reads {16'b0, REV_MAJOR[15:8], REV_MINOR[7:0]}.
- R3: A write to table control (0x20) with bit 31 = 1 stores the staged 68-bit entry into the entry selected by bits 9..0, provided that index is below DEPTH.
- R4: A write to table control with bit 31 = 0 copies the selected entry into the data words. Word 0 (0x34) returns entry bits 67..64 in its bits 3..0, with its upper 28 bits 0. Word 1 (0x38) returns bits 63..32. Word 2 (0x3C) returns bits 31..0. Table control reads back the index, with bit 31 as 0.
- R5: An index of DEPTH or above makes a commit have no effect on any entry, and makes a load fill the data words with zeros.
- R6: Writing global control (0x08) with bit 30 = 1 sets the type field (entry bits 61..60) of every entry to 0 (free), one entry per cycle starting at index 0, and leaves the other entry bits unchanged.
- R7: From the cycle after the clear write until the sweep has covered DEPTH entries, global control bit 30 (clear) and bit 16 (busy) read 1. After that they read 0 without any further write.
- R8: Table-control writes that arrive during a sweep are discarded: no commit, no load, and no index update.
- R9: Global control bits 31 (enable) and 29 (ageout) are read/write storage that resets to 0. Every other bit of that register reads 0 except bits 30 and 16.
- R10: Port p's control register is a 32-bit read/write register at 0x40 + 4*p, for p < NUM_PORTS. Unmapped addresses read 0 and ignore writes.
- R11: Read data appears on bus_rdata in the cycle after bus_rd is sampled high. In any cycle that follows one with no read, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
A register read returns its value one clock after the strobe is sampled. The bench's monitor therefore records each sampled strobe at the rising edge and compares at the following falling edge, against the value the read task queued. Table loads, commits and the start of a sweep all take effect on the same edge as their write, so the next read already shows their result. During a sweep the clear and busy bits stay high until DEPTH entries have been freed. The bench reads them immediately after the clear write, then waits DEPTH plus a margin of cycles before checking that they have dropped and inspecting the freed entries.

// File: rtl/ftr_pkg.sv
package ftr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_state_t;

    localparam int ENTRY_W  = 68;
    localparam int TYPE_LO  = 60;
    localparam int TC_IDX_W = 10;

    localparam logic [7:0] A_IDENT = 8'h00;
    localparam logic [7:0] A_GCTL  = 8'h08;
    localparam logic [7:0] A_TCTL  = 8'h20;
    localparam logic [7:0] A_DW0   = 8'h34;
    localparam logic [7:0] A_DW1   = 8'h38;
    localparam logic [7:0] A_DW2   = 8'h3C;
    localparam logic [7:0] A_PORT0 = 8'h40;

    localparam int GC_EN     = 31;
    localparam int GC_CLR    = 30;
    localparam int GC_AGE    = 29;
    localparam int GC_BUSY   = 16;
    localparam int TC_COMMIT = 31;

endpackage

// File: rtl/ftr_sweep_fsm.sv
module ftr_sweep_fsm
    import ftr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    sweep_state_t     state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             at_last;

    assign at_last = (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SWEEP && !at_last) begin
                idx_q <= idx_q + 1'b1;
            end else begin
                idx_q <= '0;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)   state_d = ST_SWEEP;
            ST_SWEEP: if (at_last) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = (state_q == ST_SWEEP);
        clr_en  = busy;
        clr_idx = idx_q;
    end

endmodule

// File: rtl/ftr_entry_store.sv
module ftr_entry_store
    import ftr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_data
);

    logic [ENTRY_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (clr_en) begin
            mem[clr_idx][TYPE_LO +: 2] <= 2'b00;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/fwd_table_regs.sv
module fwd_table_regs
    import ftr_pkg::*;
#(
    parameter int          DEPTH     = 64,
    parameter int          NUM_PORTS = 3,
    parameter logic [7:0]  REV_MAJOR = 8'h01,
    parameter logic [7:0]  REV_MINOR = 8'h02
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic                 gc_en_q, gc_age_q;
    logic [TC_IDX_W-1:0]  tc_idx_q;
    logic [ENTRY_W-1:0]   stage_q;
    logic [31:0]          port_q [NUM_PORTS];

    logic                 sweep_busy, clr_en;
    logic [IDX_W-1:0]     clr_idx;
    logic                 wr_gctl, wr_tctl, tc_accept, store_wr, sweep_start;
    logic [TC_IDX_W-1:0]  tc_field;
    logic                 in_range;
    logic [IDX_W-1:0]     tbl_idx;
    logic [ENTRY_W-1:0]   tbl_rd;
    logic [31:0]          rd_val;

    assign wr_gctl     = bus_wr && (bus_addr == A_GCTL);
    assign wr_tctl     = bus_wr && (bus_addr == A_TCTL);
    assign tc_field    = bus_wdata[TC_IDX_W-1:0];
    assign in_range    = (32'(tc_field) < 32'(DEPTH));
    assign tbl_idx     = tc_field[IDX_W-1:0];
    assign tc_accept   = wr_tctl && !sweep_busy;
    assign store_wr    = tc_accept && bus_wdata[TC_COMMIT] && in_range;
    assign sweep_start = wr_gctl && bus_wdata[GC_CLR];

    ftr_sweep_fsm #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sweep_start),
        .busy    (sweep_busy),
        .clr_en  (clr_en),
        .clr_idx (clr_idx)
    );

    ftr_entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .wr_en   (store_wr),
        .wr_idx  (tbl_idx),
        .wr_data (stage_q),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .rd_idx  (tbl_idx),
        .rd_data (tbl_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gc_en_q  <= 1'b0;
            gc_age_q <= 1'b0;
            tc_idx_q <= '0;
            stage_q  <= '0;
        end else begin
            if (wr_gctl) begin
                gc_en_q  <= bus_wdata[GC_EN];
                gc_age_q <= bus_wdata[GC_AGE];
            end
            if (tc_accept) begin
                tc_idx_q <= tc_field;
                if (!bus_wdata[TC_COMMIT]) begin
                    stage_q <= in_range ? tbl_rd : '0;
                end
            end
            if (bus_wr && bus_addr == A_DW0) stage_q[67:64] <= bus_wdata[3:0];
            if (bus_wr && bus_addr == A_DW1) stage_q[63:32] <= bus_wdata;
            if (bus_wr && bus_addr == A_DW2) stage_q[31:0]  <= bus_wdata;
        end
    end

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        localparam logic [7:0] P_ADDR = A_PORT0 + 8'(4 * gp);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                port_q[gp] <= '0;
            end else if (bus_wr && bus_addr == P_ADDR) begin
                port_q[gp] <= bus_wdata;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        case (bus_addr)
            A_IDENT: rd_val = {16'b0, REV_MAJOR, REV_MINOR};
            A_GCTL: begin
                rd_val[GC_EN]   = gc_en_q;
                rd_val[GC_CLR]  = sweep_busy;
                rd_val[GC_AGE]  = gc_age_q;
                rd_val[GC_BUSY] = sweep_busy;
            end
            A_TCTL:  rd_val = {{(32 - TC_IDX_W){1'b0}}, tc_idx_q};
            A_DW0:   rd_val = {28'b0, stage_q[67:64]};
            A_DW1:   rd_val = stage_q[63:32];
            A_DW2:   rd_val = stage_q[31:0];
            default: begin
                for (int p = 0; p < NUM_PORTS; p++) begin
                    if (bus_addr == A_PORT0 + 8'(4 * p)) rd_val = port_q[p];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_rd ? rd_val : 32'b0;
        end
    end

endmodule

// File: rtl/ftr_checker.sv
module ftr_checker #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd,
    input logic [31:0]      bus_rdata,
    input logic             busy,
    input logic [IDX_W-1:0] clr_idx,
    input logic             sweep_start
);

    // R6: sweep visits consecutive indices
    p_sweep_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (clr_idx == $past(clr_idx) + 1'b1));

    // R6: sweep begins at index 0, only after a clear request
    p_sweep_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (clr_idx == '0 && $past(sweep_start)));

    // R7: busy drops only after the last index was freed
    p_sweep_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(clr_idx) == IDX_W'(DEPTH - 1)));

    // R11: no read in the previous cycle means zero read data
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> (bus_rdata == 32'b0));

endmodule

bind fwd_table_regs ftr_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ftr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .busy        (sweep_busy),
    .clr_idx     (clr_idx),
    .sweep_start (sweep_start)
);

// File: tb/test_fwd_table_regs.sv
module test_fwd_table_regs;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic pend = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    fwd_table_regs #(.DEPTH(DEPTH), .NUM_PORTS(3),
                     .REV_MAJOR(8'h01), .REV_MINOR(8'h02)) i_fwd_table_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always @(posedge clk) pend <= bus_rd;

    // monitor: compares read data one cycle after each sampled read
    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL unexpected read data: actual %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic stage(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
        wr(8'h34, w0); wr(8'h38, w1); wr(8'h3C, w2);
    endtask

    task automatic expect_entry(input logic [9:0] idx, input logic [31:0] w0,
                                input logic [31:0] w1, input logic [31:0] w2, input string t);
        wr(8'h20, {22'b0, idx});
        rd(8'h34, w0, {t, " word0"});
        rd(8'h38, w1, {t, " word1"});
        rd(8'h3C, w2, {t, " word2"});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        n_chk++;
        if (bus_rdata !== 32'b0) begin
            n_bad++; $display("FAIL R1 rdata after reset: actual %h expected 0", bus_rdata);
        end
        rd(8'h08, 32'h0, "R1 gctl reset");
        rd(8'h20, 32'h0, "R1 tctl reset");
        rd(8'h38, 32'h0, "R1 word1 reset");
        rd(8'h00, 32'h0000_0102, "R2 ident");

        // R9: enable and ageout storage
        wr(8'h08, 32'hA000_0000);
        rd(8'h08, 32'hA000_0000, "R9 gctl rw");
        wr(8'h08, 32'h0FFF_FFFF);
        rd(8'h08, 32'h0, "R9 gctl other bits");

        // R7: clear sweep on an empty table
        wr(8'h08, 32'hE000_0000);
        rd(8'h08, 32'hE001_0000, "R7 clear/busy during sweep");
        repeat (DEPTH + 4) @(negedge clk);
        rd(8'h08, 32'hA000_0000, "R7 clear/busy after sweep");

        // R11: no read, zero data
        @(negedge clk);
        n_chk++;
        if (bus_rdata !== 32'b0) begin
            n_bad++; $display("FAIL R11 idle rdata: actual %h expected 0", bus_rdata);
        end

        // R3: commits
        stage(32'hFFFF_FFF7, 32'h1234_5678, 32'h9ABC_DEF0);
        wr(8'h20, 32'h8000_0005);
        stage(32'h0000_0003, 32'h2000_0ABC, 32'h1111_1111);
        wr(8'h20, 32'h8000_003F);
        stage(32'h0000_000A, 32'h3000_0001, 32'h55AA_55AA);
        wr(8'h20, 32'h8000_0000);

        // R4: load and word order
        stage(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        expect_entry(10'd5, 32'h7, 32'h1234_5678, 32'h9ABC_DEF0, "R4 load idx5");
        rd(8'h20, 32'h5, "R4 tctl index readback");
        expect_entry(10'd63, 32'h3, 32'h2000_0ABC, 32'h1111_1111, "R3 commit idx63");

        // R5: out-of-range index
        stage(32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        wr(8'h20, 32'h8000_0040);
        expect_entry(10'd64, 32'h0, 32'h0, 32'h0, "R5 load out of range");
        expect_entry(10'd0, 32'hA, 32'h3000_0001, 32'h55AA_55AA, "R5 commit out of range no alias");

        // R6 / R8: clear with a table write during the sweep
        stage(32'h0000_0001, 32'h0BAD_0BAD, 32'h0BAD_0BAD);
        wr(8'h08, 32'hE000_0000);
        wr(8'h20, 32'h8000_0005);
        wr(8'h20, 32'h0000_0007);
        rd(8'h08, 32'hE001_0000, "R7 busy bit while sweeping");
        repeat (DEPTH + 4) @(negedge clk);
        rd(8'h20, 32'h0, "R8 tctl index unchanged");
        rd(8'h38, 32'h0BAD_0BAD, "R8 no load during sweep");
        expect_entry(10'd5, 32'h7, 32'h0234_5678, 32'h9ABC_DEF0, "R6 R8 idx5 freed, commit discarded");
        expect_entry(10'd63, 32'h3, 32'h0000_0ABC, 32'h1111_1111, "R6 idx63 freed");
        expect_entry(10'd0, 32'hA, 32'h0000_0001, 32'h55AA_55AA, "R6 idx0 freed");

        // R10: port registers and unmapped space
        wr(8'h40, 32'h0101_0101);
        wr(8'h44, 32'h0202_0202);
        wr(8'h48, 32'h0303_0303);
        wr(8'h4C, 32'hFFFF_FFFF);
        rd(8'h40, 32'h0101_0101, "R10 port0");
        rd(8'h44, 32'h0202_0202, "R10 port1");
        rd(8'h48, 32'h0303_0303, "R10 port2");
        rd(8'h4C, 32'h0, "R10 beyond last port");
        rd(8'h10, 32'h0, "R10 unmapped");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R11 missing read data: actual %0d pending expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule